// File: doc/BRIEF.md
# Quarter-Phase Leading-Edge Time Digitizer

This block assigns an arrival time to the leading edge of one discriminator channel. A free-running coarse counter advances on every main clock edge. Alongside it, four copies of the clock, each delayed by a quarter period, sample the discriminator output. The block registers those four samples into the main clock domain. When a new edge appears, it takes the index of the earliest phase that saw the signal high as a two-bit fine code. The resulting time unit is a quarter of the clock period: 0.625 ns at 400 MHz.

Each recorded edge becomes one timestamp word: the coarse count joined to the fine code, with a fixed channel number in the top bits. The word goes into a small FIFO that drains through a valid/ready stream. After an edge is recorded, the channel stays blind until it has seen a whole clock period with the input low on all four phases. If the FIFO is full when an edge is detected, the edge is discarded and an overflow counter records the loss.

With a 12-bit coarse field at 400 MHz, the timestamp spans about 10 µs before it wraps. That covers the required 2 µs window without ambiguity. Two hits separated by a single all-low clock period are both kept, which is well under 25 ns at that clock.

Top module: `qtdc_channel`

## Requirements
- R1: While and after reset, before any recorded edge, `out_valid` is 0 and `ovf_count` is 0.
- R2: Bit i of `phase_in` is the sample from phase i, and phase 0 is the earliest. The fine code in `out_data[1:0]` is the lowest i whose bit is 1 in the sampled word that holds the edge.
- R3: The coarse field `out_data[13:2]` equals the number of clock edges since reset release that came before the edge capturing the sampled word, modulo 4096. The counter wraps from 4095 to 0.
- R4: Only the first sampled word with any bit high after re-arming is recorded. Further words in which the input stays high produce no record.
- R5: After a record, no further record is made until a sampled word with all four bits 0 has been seen. An input held high through reset release is not recorded until it has first gone low.
- R6: `out_data[17:14]` carries the `CHAN_ID` parameter.
- R7: The FIFO holds 4 words. An edge detected while 4 words are held is discarded even if a word leaves in that cycle. Each discarded edge adds 1 to `ovf_count`, which saturates at 255.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is unchanged. Words leave in the order their edges arrived.
- R9: With an empty FIFO, a word presented on `phase_in` before clock edge E that holds a recordable edge makes `out_valid` 1 after edge E+1, and not after edge E.
- R10: Two edges whose words are separated by a single all-low word are both recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; the coarse counter advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_in | input | 4 | Discriminator samples from the four quarter-period phases, bit 0 earliest |
| out_valid | output | 1 | A timestamp word is available |
| out_ready | input | 1 | The consumer accepts the word on this clock edge |
| out_data | output | 18 | Channel number, coarse count and fine code |
| ovf_count | output | 8 | Saturating count of edges discarded while the FIFO was full |

## Verification
The assertions assume that `phase_in` is already settled in the main clock domain at each rising edge, one four-bit word per clock period. They also assume that `out_ready` changes only between edges. The bench drives both one nanosecond after each rising edge, so each word is captured whole, and never toggles them near an edge. The property on held output data presumes that the consumer, not the block, decides when a word leaves. The bench therefore holds `out_ready` low for long stretches while edges keep arriving, so that the full and overflow paths are visited under that assumption.

// File: rtl/qtdc_pkg.sv
package qtdc_pkg;

  // Index of the lowest set bit among the first n bits of v (0 if none).
  function automatic int unsigned qtdc_first_high(logic [31:0] v, int unsigned n);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && v[i]) idx = i;
    end
    return idx;
  endfunction

  // Timestamp value: coarse count scaled by the phase count plus the fine code.
  function automatic longint unsigned qtdc_stamp(longint unsigned coarse,
                                                 int unsigned fine,
                                                 int unsigned nph);
    return coarse * nph + fine;
  endfunction

endpackage

// File: rtl/qtdc_phase_front.sv
module qtdc_phase_front #(
  parameter int NPH    = 4,
  parameter int FINE_W = $clog2(NPH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPH-1:0]    phase_in,
  output logic [NPH-1:0]    samp_q,
  output logic              armed_q,
  output logic              hit_fire,
  output logic [FINE_W-1:0] hit_fine
);
  import qtdc_pkg::*;

  logic any_high;
  logic all_low;

  // Reset value all-high: the channel must see a real low before it arms.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      samp_q  <= '1;
      armed_q <= 1'b0;
    end else begin
      samp_q <= phase_in;
      if (all_low)       armed_q <= 1'b1;
      else if (hit_fire) armed_q <= 1'b0;
    end
  end

  assign any_high = |samp_q;
  assign all_low  = ~any_high;
  assign hit_fire = armed_q & any_high;
  assign hit_fine = FINE_W'(qtdc_first_high(32'(samp_q), NPH));

endmodule

// File: rtl/qtdc_coarse.sv
module qtdc_coarse #(
  parameter int COARSE_W = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic [COARSE_W-1:0] coarse_now,
  output logic [COARSE_W-1:0] coarse_at_samp
);
  // coarse_at_samp is the count that was current when samp_q was captured.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coarse_now     <= '0;
      coarse_at_samp <= '0;
    end else begin
      coarse_now     <= coarse_now + 1'b1;
      coarse_at_samp <= coarse_now;
    end
  end
endmodule

// File: rtl/qtdc_fifo.sv
module qtdc_fifo #(
  parameter int DW    = 18,
  parameter int DEPTH = 4,
  parameter int OVF_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic [DW-1:0]    push_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             fifo_full,
  output logic             hit_drop,
  output logic [OVF_W-1:0] ovf_count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   level;
  logic          push_ok, pop;

  assign fifo_full = (level == DEPTH_C);
  assign push_ok   = push_req & ~fifo_full;
  assign hit_drop  = push_req &  fifo_full;
  assign out_valid = (level != '0);
  assign pop       = out_valid & out_ready;
  assign out_data  = mem[rd_ptr];

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      level     <= '0;
      ovf_count <= '0;
    end else begin
      if (push_ok) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= ptr_next(wr_ptr);
      end
      if (pop) rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      if (hit_drop && ovf_count != OVF_MAX) ovf_count <= ovf_count + 1'b1;
    end
  end
endmodule

// File: rtl/qtdc_channel.sv
module qtdc_channel #(
  parameter int NPH        = 4,
  parameter int COARSE_W   = 12,
  parameter int CHAN_W     = 4,
  parameter int CHAN_ID    = 0,
  parameter int FIFO_DEPTH = 4,
  parameter int OVF_W      = 8,
  localparam int FINE_W    = $clog2(NPH),
  localparam int TS_W      = COARSE_W + FINE_W,
  localparam int DW        = CHAN_W + TS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPH-1:0]   phase_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic [OVF_W-1:0] ovf_count
);
  import qtdc_pkg::*;

  logic [NPH-1:0]      samp_q;
  logic                armed_q;
  logic                hit_fire;
  logic [FINE_W-1:0]   hit_fine;
  logic [COARSE_W-1:0] coarse_now;
  logic [COARSE_W-1:0] coarse_at_samp;
  logic                fifo_full;
  logic                hit_drop;
  logic [TS_W-1:0]     stamp;
  logic [DW-1:0]       word;

  qtdc_phase_front #(.NPH(NPH), .FINE_W(FINE_W)) u_front (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .samp_q(samp_q),
    .armed_q(armed_q), .hit_fire(hit_fire), .hit_fine(hit_fine)
  );

  qtdc_coarse #(.COARSE_W(COARSE_W)) u_coarse (
    .clk(clk), .rst_n(rst_n), .coarse_now(coarse_now),
    .coarse_at_samp(coarse_at_samp)
  );

  assign stamp = TS_W'(qtdc_stamp(longint'(coarse_at_samp), int'(hit_fine), NPH));
  assign word  = {CHAN_W'(CHAN_ID), stamp};

  qtdc_fifo #(.DW(DW), .DEPTH(FIFO_DEPTH), .OVF_W(OVF_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_req(hit_fire), .push_data(word),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fifo_full(fifo_full), .hit_drop(hit_drop), .ovf_count(ovf_count)
  );

endmodule

// File: rtl/qtdc_channel_chk.sv
module qtdc_channel_chk #(
  parameter int NPH   = 4,
  parameter int DW    = 18,
  parameter int OVF_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPH-1:0]   samp_q,
  input logic             armed_q,
  input logic             hit_fire,
  input logic             fifo_full,
  input logic             hit_drop,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic [OVF_W-1:0] ovf_count
);
  localparam logic [OVF_W-1:0] OVF_MAX = '1;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_blind_after_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |=> !armed_q || $past(samp_q) == '0);

  assert_no_hit_unarmed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !hit_fire);

  assert_hit_needs_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire |-> samp_q != '0);

  assert_drop_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire && fifo_full |-> hit_drop);

  assert_ovf_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hit_drop && ovf_count != OVF_MAX |=> ovf_count == $past(ovf_count) + 1'b1);

  assert_ovf_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_drop |=> $stable(ovf_count));

  assert_push_visible_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_fire && !fifo_full |=> out_valid);

endmodule

bind qtdc_channel qtdc_channel_chk #(.NPH(NPH), .DW(DW), .OVF_W(OVF_W)) u_chk (.*);

// File: tb/sim_qtdc_channel.sv
`timescale 1ns/1ps
module sim_qtdc_channel;
  localparam int ID = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  phase_in = 4'hF;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [17:0] out_data;
  logic [7:0]  ovf_count;

  int checks = 0, errors = 0;
  int bcnt = 0;
  logic [17:0] exp_mem [0:1023];
  int exp_wr = 0, exp_rd = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  qtdc_channel #(.CHAN_ID(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .phase_in(phase_in), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .ovf_count(ovf_count)
  );

  // Edges since reset release.
  always @(posedge clk) bcnt <= rst_n ? bcnt + 1 : 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // Consumer side: every accepted word must match the next expected one.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_rd < exp_wr) begin
        check(out_data == exp_mem[exp_rd % 1024], "R2 R3 R6 R8 record",
              out_data, exp_mem[exp_rd % 1024]);
        exp_rd++;
      end else
        check(1'b0, "R4 R5 unexpected record", out_data, 0);
    end
  end

  function automatic int low_idx(logic [3:0] p);
    for (int i = 0; i < 4; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic step(input logic [3:0] p);
    @(posedge clk); #1; phase_in = p;
  endtask

  task automatic hit(input logic [3:0] p, input bit keep);
    @(posedge clk); #1;
    if (keep) begin
      exp_mem[exp_wr % 1024] = {4'(ID), 12'(bcnt % 4096), 2'(low_idx(p))};
      exp_wr++;
    end
    phase_in = p;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(4'h0);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R1 valid in reset", out_valid, 0);
    check(ovf_count == 0, "R1 ovf in reset", ovf_count, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    // R5: input high across reset release is not a record
    step(4'hF); step(4'hF); step(4'hF);
    @(negedge clk);
    check(out_valid == 0, "R5 R1 no record while held high", out_valid, 0);
    check(ovf_count == 0, "R1 ovf after reset", ovf_count, 0);
    step(4'h0);

    // R9 latency
    @(posedge clk); #1; out_ready = 1'b0;
    hit(4'b0010, 1);
    step(4'h0);
    @(negedge clk);
    check(out_valid == 0, "R9 not after first edge", out_valid, 0);
    @(posedge clk); @(negedge clk);
    check(out_valid == 1, "R9 valid after second edge", out_valid, 1);
    check(out_data == exp_mem[0], "R9 R2 data", out_data, exp_mem[0]);
    @(posedge clk); #1; out_ready = 1'b1;
    idle(3);

    // R2 R4 exhaustive sweep of phase patterns with varied high durations
    for (int p = 1; p < 16; p++) begin
      hit(4'(p), 1);
      for (int k = 0; k < p % 3; k++) step(4'hF);
      idle(1);
    end
    idle(6);
    check(exp_rd == exp_wr, "R2 R4 sweep record count", exp_rd, exp_wr);

    // R5 dead time: no all-low word between highs
    hit(4'b1000, 1); step(4'b0001); step(4'b1000); idle(1);
    hit(4'b0011, 1); step(4'b1100); idle(6);
    check(exp_rd == exp_wr, "R5 dead time records", exp_rd, exp_wr);

    // R10 minimum spacing
    hit(4'b0001, 1); idle(1); hit(4'b0100, 1); idle(6);
    check(exp_rd == exp_wr, "R10 both close hits kept", exp_rd, exp_wr);

    // R3 counter wrap
    while ((bcnt % 4096) != 4092) step(4'h0);
    hit(4'b0100, 1); idle(1);
    hit(4'b1000, 1); idle(1);
    hit(4'b0001, 1); idle(6);
    check(exp_rd == exp_wr, "R3 wrap records", exp_rd, exp_wr);

    // R7 R8 backpressure and overflow
    @(posedge clk); #1; out_ready = 1'b0;
    for (int i = 0; i < 6; i++) begin
      hit(4'(1 << (i % 4)), i < 4); idle(1);
    end
    idle(2);
    @(negedge clk);
    check(ovf_count == 2, "R7 two dropped", ovf_count, 2);
    check(out_valid == 1, "R8 valid held", out_valid, 1);
    check(out_data == exp_mem[exp_rd % 1024], "R8 head word", out_data, exp_mem[exp_rd % 1024]);
    idle(3);
    @(negedge clk);
    check(out_data == exp_mem[exp_rd % 1024], "R8 head stable", out_data, exp_mem[exp_rd % 1024]);
    for (int i = 0; i < 260; i++) begin hit(4'b0010, 0); idle(1); end
    idle(2);
    @(negedge clk);
    check(ovf_count == 255, "R7 saturation", ovf_count, 255);
    @(posedge clk); #1; out_ready = 1'b1;
    idle(10);
    check(exp_rd == exp_wr, "R7 R8 stored words drained in order", exp_rd, exp_wr);
    @(negedge clk);
    check(out_valid == 0, "R7 no dropped word delivered", out_valid, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule